// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line-Status Interrupts

This block receives asynchronous serial characters on a single input line. An external enable pulse arrives at sixteen times the bit rate. The receiver finds the falling edge that opens each character and reads every bit near its centre by taking a majority of three consecutive samples. It then writes the character, together with its own parity, framing and break flags, into a sixteen-entry receive queue. The frame format can be set at run time: word length, parity handling, and one or two stop bits.

The host side reads the character at the head of the queue through `dout` and removes it with a one-cycle `rd_data` strobe. It acknowledges error conditions with a one-cycle `rd_lsr` strobe. A three-bit interrupt identification output ranks the pending causes. Error conditions come first. Below them are "queue filled to the trigger level" and "characters left waiting with no queue activity for four character times". The code 3'b001 means nothing is pending.

Top module: `uart_rx_lsi`

## Requirements
- R1: One bit lasts 16 `tick16` pulses. While idle, the first tick that sees the line low begins a character. Each bit is decided by a majority of the samples on the 7th, 8th and 9th ticks of that bit. An inverted pulse one tick wide inside a bit does not change the received value.
- R2: If the start bit is decided as 1 at its midpoint, the receiver goes back to idle and stores nothing.
- R3: Data bits arrive least significant bit first. `word_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The unused upper bits of `dout` read as 0.
- R4: When `par_en`=1, one parity bit follows the data. `par_kind` selects its expected value: 0 = odd, 1 = even, 2 = always 1, 3 = always 0. A mismatch sets the entry's parity flag.
- R5: When `two_stop`=1, two stop bits are expected; otherwise one. A stop bit decided as 0 sets the entry's framing flag.
- R6: A character whose every bit is decided as 0, including the stop bits, is stored as 0x00 with both the break flag and the framing flag set. No further character starts until the line has returned high.
- R7: The queue holds 16 entries. `ls_dr` is 1 exactly when the queue is not empty. `dout` and the flags show the head entry. `rd_data` removes the head entry, and has no effect when the queue is empty.
- R8: A character that completes while the queue is full is discarded, the queue contents are kept, and `ls_oe` is set. `ls_oe` is cleared by `rd_lsr`.
- R9: The parity, framing and break flags travel with each entry and appear on `ls_pe`, `ls_fe` and `ls_bi` when that entry is at the head. After `rd_lsr` they read 0 until the head entry is removed.
- R10: `int_id` is 3'b011 whenever any of `ls_oe`, `ls_pe`, `ls_fe` or `ls_bi` is 1. This cause outranks every other.
- R11: `trig_sel` values 0, 1, 2 and 3 select trigger levels of 1, 4, 8 and 14 characters. With no line-status cause pending, `int_id` is 3'b010 while the fill is at or above the trigger level.
- R12: With the queue not empty and below the trigger level, `int_id` becomes 3'b110 once 4 character times pass with no push or pop. One character time is 16 ticks multiplied by the frame's bit count. A push or a pop restarts the count.
- R13: With no cause pending, `int_id` is 3'b001. This is also the value after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| word_sel | input | 2 | Data bit count select (5 to 8) |
| par_en | input | 1 | Parity bit present |
| par_kind | input | 2 | Parity kind: odd, even, always 1, always 0 |
| two_stop | input | 1 | Expect two stop bits |
| trig_sel | input | 2 | Trigger level select (1, 4, 8, 14) |
| rd_data | input | 1 | Remove the head entry |
| rd_lsr | input | 1 | Acknowledge line status |
| dout | output | 8 | Head character |
| ls_dr | output | 1 | Queue not empty |
| ls_oe | output | 1 | Overrun occurred |
| ls_pe | output | 1 | Head entry parity error |
| ls_fe | output | 1 | Head entry framing error |
| ls_bi | output | 1 | Head entry break |
| int_id | output | 3 | Highest pending interrupt cause |

## Verification
The bench builds the block with its defaults: a 16-entry queue, 16 ticks per bit, and a four-character timeout. With these values, a seventeenth unread character reaches the overrun case, and the trigger level of 14 sits inside the queue depth. The timeout fires about 1280 clocks after the last queue activity when the tick comes on every second clock, so both the "not yet" point and the "fired" point of the timeout window can be sampled. The bench also places a one-tick glitch inside a data bit, a short low pulse that mimics a false start, and a line held low across two frames.

// File: rtl/uart_rx_lsi.sv
module uart_rx_lsi #(
  parameter int DEPTH    = 16,
  parameter int OSR      = 16,
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] word_sel,
  input  logic       par_en,
  input  logic [1:0] par_kind,
  input  logic       two_stop,
  input  logic [1:0] trig_sel,
  input  logic       rd_data,
  input  logic       rd_lsr,
  output logic [7:0] dout,
  output logic       ls_dr,
  output logic       ls_oe,
  output logic       ls_pe,
  output logic       ls_fe,
  output logic       ls_bi,
  output logic [2:0] int_id
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = AW + 1;
  localparam int CW   = $clog2(OSR);
  localparam int TOW  = $clog2(12 * OSR * TO_CHARS + 1);
  localparam logic [CW-1:0]   MIDV  = CW'(OSR / 2);
  localparam logic [CNTW-1:0] FULLV = CNTW'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_BRK} st_t;

  st_t st;
  logic [1:0] sync, samp;
  logic [CW-1:0] cnt;
  logic [2:0] bidx;
  logic [7:0] shreg;
  logic pbad, fbad1, allz;

  wire rx_s  = sync[1];
  wire vote  = (samp[0] & samp[1]) | (samp[0] & rx_s) | (samp[1] & rx_s);
  wire mid   = tick16 && (cnt == MIDV);
  wire [2:0] last = {1'b0, word_sel} + 3'd4;

  logic par_exp;
  always_comb
    unique case (par_kind)
      2'd0: par_exp = ~^shreg;
      2'd1: par_exp = ^shreg;
      2'd2: par_exp = 1'b1;
      default: par_exp = 1'b0;
    endcase

  wire push_now = mid && ((st == S_STOP1 && !two_stop) || st == S_STOP2);
  wire fe_now   = ((st == S_STOP2) & fbad1) | ~vote;
  wire bi_now   = allz & ~vote;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync <= 2'b11; samp <= 2'b11; st <= S_IDLE; cnt <= '0;
      bidx <= '0; shreg <= '0; pbad <= 1'b0; fbad1 <= 1'b0; allz <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      if (tick16) begin
        samp <= {samp[0], rx_s};
        if (st != S_IDLE && st != S_BRK) cnt <= cnt + 1'b1;
        unique case (st)
          S_IDLE: if (!rx_s) begin st <= S_START; cnt <= CW'(1); end
          S_START: if (mid) begin
            if (vote) st <= S_IDLE;
            else begin
              st <= S_DATA; bidx <= '0; shreg <= '0;
              pbad <= 1'b0; fbad1 <= 1'b0; allz <= 1'b1;
            end
          end
          S_DATA: if (mid) begin
            shreg[bidx] <= vote;
            allz <= allz & ~vote;
            bidx <= bidx + 1'b1;
            if (bidx == last) st <= par_en ? S_PAR : S_STOP1;
          end
          S_PAR: if (mid) begin
            pbad <= vote ^ par_exp;
            allz <= allz & ~vote;
            st <= S_STOP1;
          end
          S_STOP1: if (mid) begin
            fbad1 <= ~vote;
            allz <= allz & ~vote;
            st <= two_stop ? S_STOP2 : (bi_now ? S_BRK : S_IDLE);
          end
          S_STOP2: if (mid) st <= bi_now ? S_BRK : S_IDLE;
          S_BRK: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end

  logic [10:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CNTW-1:0] count;
  logic mask;
  logic [TOW-1:0] tcnt;

  wire full = (count == FULLV);
  wire push = push_now && !full;
  wire pop  = rd_data && (count != '0);

  always_ff @(posedge clk)
    if (push) mem[wp] <= {bi_now, fe_now, pbad, shreg};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; ls_oe <= 1'b0; mask <= 1'b0; tcnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + CNTW'(push) - CNTW'(pop);
      if (push_now && full) ls_oe <= 1'b1;
      else if (rd_lsr)      ls_oe <= 1'b0;
      if (pop || count == '0) mask <= 1'b0;
      else if (rd_lsr)        mask <= 1'b1;
      if (push || pop || count == '0) tcnt <= '0;
      else if (tick16 && tcnt < to_lim) tcnt <= tcnt + 1'b1;
    end

  wire [3:0] fbits = 4'd7 + {2'b00, word_sel} + {3'b000, par_en} + {3'b000, two_stop};
  wire [TOW-1:0] to_lim = TOW'(fbits) * TOW'(OSR * TO_CHARS);

  logic [CNTW-1:0] trig_lvl;
  always_comb
    unique case (trig_sel)
      2'd0: trig_lvl = CNTW'(1);
      2'd1: trig_lvl = CNTW'(4);
      2'd2: trig_lvl = CNTW'(8);
      default: trig_lvl = CNTW'(14);
    endcase

  wire [10:0] head = mem[rp];
  assign ls_dr = (count != '0);
  assign dout  = ls_dr ? head[7:0] : 8'h00;
  assign ls_pe = ls_dr & ~mask & head[8];
  assign ls_fe = ls_dr & ~mask & head[9];
  assign ls_bi = ls_dr & ~mask & head[10];

  wire ls_any = ls_oe | ls_pe | ls_fe | ls_bi;
  wire to_hit = ls_dr && (tcnt >= to_lim);

  always_comb
    if (ls_any)                        int_id = 3'b011;
    else if (ls_dr && count >= trig_lvl) int_id = 3'b010;
    else if (to_hit)                   int_id = 3'b110;
    else                               int_id = 3'b001;

  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_now && full && !rd_data) |=> (count == FULLV && ls_oe));
  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && count == '0 && !push_now) |=> (count == '0));
  assert_break_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BRK && !rx_s) |=> (st == S_BRK));
  assert_ls_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ls_oe |-> (int_id == 3'b011));
  assert_timeout_nonempty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id == 3'b110) |-> ls_dr);
endmodule

// File: tb/uart_rx_lsi_tb.sv
module uart_rx_lsi_tb;
  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1;
  logic [1:0] word_sel = 2'd3, par_kind = 2'd0, trig_sel = 2'd0;
  logic par_en = 0, two_stop = 0, rd_data = 0, rd_lsr = 0;
  logic [7:0] dout;
  logic ls_dr, ls_oe, ls_pe, ls_fe, ls_bi;
  logic [2:0] int_id;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [10:0] expq[$];
  bit mask_next = 0;

  uart_rx_lsi u_dut (.clk, .rst_n, .tick16, .rxd, .word_sel, .par_en, .par_kind,
    .two_stop, .trig_sel, .rd_data, .rd_lsr, .dout, .ls_dr, .ls_oe, .ls_pe,
    .ls_fe, .ls_bi, .int_id);

  always #2 clk = ~clk;
  always @(posedge clk) tick16 <= ~tick16;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares the head entry with the scoreboard whenever it is removed
  always @(posedge clk) if (rd_data) begin
    logic [10:0] e;
    n_chk++;
    if (expq.size() == 0) begin
      n_bad++; $display("FAIL R7 pop with empty scoreboard: actual %0h expected none", dout);
    end else begin
      e = expq.pop_front();
      if (mask_next) begin e[10:8] = 3'b000; mask_next = 0; end
      if ({ls_bi, ls_fe, ls_pe, dout} !== e) begin
        n_bad++;
        $display("FAIL R3/R7/R9 head entry: actual %0h expected %0h", {ls_bi, ls_fe, ls_pe, dout}, e);
      end
    end
  end

  task automatic bitx(input logic b, input bit g);
    for (int c = 0; c < 32; c++) begin
      @(negedge clk); rxd = (g && (c == 14 || c == 15)) ? ~b : b;
    end
  endtask

  task automatic stopx(input bit bad);
    for (int c = 0; c < 32; c++) begin
      @(negedge clk); rxd = !(bad && c < 20);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit badpar = 0, input bit bads1 = 0,
                      input bit bads2 = 0, input bit maj = 0, input bit keep = 1);
    int nb;
    logic [7:0] dm;
    logic pb;
    nb = 5 + int'(word_sel);
    dm = d & (8'hFF >> (8 - nb));
    case (par_kind)
      2'd0: pb = ~^dm;
      2'd1: pb = ^dm;
      2'd2: pb = 1'b1;
      default: pb = 1'b0;
    endcase
    if (badpar) pb = ~pb;
    if (keep) expq.push_back({1'b0, bads1 | (two_stop & bads2), par_en & badpar, dm});
    bitx(1'b0, 0);
    for (int i = 0; i < nb; i++) bitx(dm[i], maj && i == 2);
    if (par_en) bitx(pb, 0);
    stopx(bads1);
    if (two_stop) stopx(bads2);
    repeat (4) @(negedge clk);
  endtask

  task automatic pop1();
    @(negedge clk) rd_data = 1;
    @(negedge clk) rd_data = 0;
  endtask

  task automatic ack();
    @(negedge clk) rd_lsr = 1;
    @(negedge clk) rd_lsr = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13 reset int_id", int_id, 3'b001);
    chk("R7 reset ls_dr", ls_dr, 0);

    send(8'hA5);
    chk("R11 trigger 1 reached", int_id, 3'b010);
    pop1();
    chk("R13 idle after pop", int_id, 3'b001);
    send(8'h3C, 0, 0, 0, 1);
    pop1();                                   // R1 majority vote hides a one-tick glitch

    @(negedge clk) rxd = 0;
    repeat (8) @(negedge clk);
    rxd = 1;
    repeat (64) @(negedge clk);
    chk("R2 false start stores nothing", ls_dr, 0);

    for (int w = 0; w < 3; w++) begin        // R3 shorter words, upper bits zero
      word_sel = 2'(w);
      send(8'hD6 ^ 8'(w));
      pop1();
    end

    word_sel = 2'd2; par_en = 1;
    for (int k = 0; k < 4; k++) begin        // R4 all parity kinds, correct parity
      par_kind = 2'(k);
      send(8'h4B + 8'(k));
      chk("R4 good parity no flag", ls_pe, 0);
      pop1();
    end
    par_kind = 2'd1;
    send(8'h2D, 1);
    chk("R4 parity flag", ls_pe, 1);
    chk("R10 line status id", int_id, 3'b011);
    ack();
    chk("R9 flag hidden after ack", ls_pe, 0);
    chk("R11 data id after ack", int_id, 3'b010);
    mask_next = 1;
    pop1();

    par_en = 0; word_sel = 2'd3; two_stop = 1;
    send(8'h81);
    chk("R5 two stops good", ls_fe, 0);
    pop1();
    send(8'h7E, 0, 0, 1);
    chk("R5 second stop low", ls_fe, 1);
    pop1();
    two_stop = 0;
    send(8'h18, 0, 1);
    chk("R5 single stop low", ls_fe, 1);
    pop1();

    @(negedge clk) rxd = 0;                   // R6 line held low
    repeat (640) @(negedge clk);
    rxd = 1;
    repeat (64) @(negedge clk);
    expq.push_back(11'h600);
    chk("R6 break flag", ls_bi, 1);
    pop1();
    chk("R6 only one entry", ls_dr, 0);

    trig_sel = 2'd3;
    for (int i = 0; i < 16; i++) send(8'(i * 13 + 1));
    chk("R8 no overrun when just full", ls_oe, 0);
    send(8'hEE, 0, 0, 0, 0, 0);
    chk("R8 overrun flag", ls_oe, 1);
    chk("R10 overrun id", int_id, 3'b011);
    ack();
    chk("R8 overrun cleared", ls_oe, 0);
    chk("R11 trigger 14 id", int_id, 3'b010);
    for (int i = 0; i < 16; i++) pop1();     // R8 first sixteen kept
    chk("R7 drained", ls_dr, 0);

    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) send(8'h90 + 8'(i));
    chk("R11 below trigger 4", int_id, 3'b001);
    send(8'h99);
    chk("R11 at trigger 4", int_id, 3'b010);
    pop1();
    chk("R11 fell below trigger", int_id, 3'b001);
    repeat (3) pop1();

    trig_sel = 2'd3;
    send(8'h11);
    send(8'h22);
    chk("R12 no timeout yet", int_id, 3'b001);
    repeat (956) @(negedge clk);
    chk("R12 before four chars", int_id, 3'b001);
    repeat (640) @(negedge clk);
    chk("R12 timeout id", int_id, 3'b110);
    pop1();
    chk("R12 pop restarts count", int_id, 3'b001);
    pop1();
    chk("R7 empty at end", ls_dr, 0);
    chk("R13 nothing pending at end", int_id, 3'b001);
    finish_run();
  end
endmodule